// File: doc/BRIEF.md
# Center-Aligned Buffered PWM Generator

This block drives several PWM outputs from one shared time base. The time base is chosen by a 2-bit mode. It can be a wrapping up counter, an up counter that runs for a single period, or an up/down counter in one of two variants. Each channel compares its duty value against the running count. In the up-counting modes the output is edge aligned, starting at count zero. In the up/down modes it is center aligned around count zero.

Software writes duty values into per-channel buffer registers at any time. The value the comparator actually uses sits in a second, hidden register. That register takes the buffer value only at boundaries that depend on the mode, so a change never cuts a pulse short or adds a stray edge. While the time base is stopped, a buffer write goes directly into the compare register. The first period after enabling then already uses the new duty.

The period value and the mode are expected to stay fixed while the time base runs. Duty changes are made through the buffers.

Top module: `pwm_center_gen`

## Requirements
- R1: After reset the count is 0, the direction flag is 0 (up) and all PWM outputs are 0.
- R2: In modes 10 and 11 the count goes 0,1,…,P with direction 0, then P-1,…,0 with direction 1, then turns back up. One cycle lasts 2·P clocks, where P is the period value (P ≥ 2).
- R3: In mode 00 (free running) the count goes 0…P and then wraps to 0, so a period lasts P+1 clocks. An output is 1 exactly while count < duty.
- R4: In mode 01 (single period) the count runs 0…P once, then holds at 0 with all outputs 0 while the enable stays high. Dropping the enable and raising it again starts a new period.
- R5: In modes 10 and 11 an output goes to 1 when the count equals the duty while the direction is 1. It goes to 0 when the count equals the duty while the direction is 0. For 1 ≤ duty < P it is therefore high for 2·duty clocks of each cycle.
- R6: A duty of 0 keeps the output at 0 for the whole period in every mode.
- R7: A duty greater than P keeps the output at 1 for the whole period in every mode.
- R8: In modes 00 and 01 a buffered duty reaches the compare register when the count matches P. It takes effect from the following count-0 clock.
- R9: In mode 10 a buffered duty reaches the compare register only at the bottom turnaround, where the count is 0 with direction 1.
- R10: In mode 11 a buffered duty reaches the compare register both at the bottom turnaround and at the top, where the count equals P with direction 0.
- R11: While the enable is 0, the count is 0, the direction is 0, outputs are 0, and a duty write is copied into the compare register on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Time base enable |
| mode_i | input | 2 | Time base mode: 00 free running, 01 single period, 10 up/down, 11 up/down with two loads |
| period_i | input | CNT_W | Period value P |
| duty_we_i | input | N_CH | Per-channel duty buffer write strobe |
| duty_wdata_i | input | CNT_W | Duty value written by the strobed channels |
| pwm_o | output | N_CH | PWM outputs, one bit per channel |
| count_o | output | CNT_W | Time base count |
| dir_o | output | 1 | Direction flag, 1 while counting down |

## Verification
Each mode is run with duties of zero, strictly inside the period, one below the period and above the period. The high time per cycle is counted, which tells the edge-aligned law (duty clocks) from the center-aligned law (twice duty) and shows the two saturation ends. Duty writes are then issued mid-period, at a point where the old and new compare values give different outputs. Sampling before and after each candidate load boundary separates the single-load, double-load and period-match policies. Short traces of the count and direction, a single-period run with re-arm, and a disabled-time write check the time base and the direct load path.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    TB_FREE       = 2'b00,
    TB_ONESHOT    = 2'b01,
    TB_CENTER     = 2'b10,
    TB_CENTER_DBL = 2'b11
  } tb_mode_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  tb_mode_e         mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             run_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic             done_q;
  logic             run;
  logic             at_top;
  logic             at_bot;
  logic             center;

  assign run    = en_i && !done_q;
  assign at_top = cnt_q >= period_i;
  assign at_bot = cnt_q == '0;
  assign center = mode_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (done_q) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (center) begin
      if (!dir_q) begin
        if (at_top) begin
          dir_q <= 1'b1;
          cnt_q <= at_bot ? cnt_q : cnt_q - ONE;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else begin
        if (at_bot) begin
          dir_q <= 1'b0;
          cnt_q <= at_top ? cnt_q : cnt_q + ONE;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end else begin
      if (at_top) begin
        cnt_q <= '0;
        if (mode_i == TB_ONESHOT) done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  // buffer-to-compare copy points per mode
  always_comb begin
    load_o = 1'b0;
    if (run) begin
      unique case (mode_i)
        TB_FREE, TB_ONESHOT: load_o = at_top;
        TB_CENTER:           load_o = dir_q && at_bot;
        TB_CENTER_DBL:       load_o = (dir_q && at_bot) || (!dir_q && at_top);
        default:             load_o = 1'b0;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;
  assign run_o = run;

  // R2
  dir_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && center && !dir_q && cnt_q == period_i && period_i > ONE)
      |=> (dir_q || cnt_q == '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (cnt_q == '0 && !dir_q));

  // R4
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mode_i == TB_ONESHOT && at_top && en_i) |=> (cnt_q == '0 && !run));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             center_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] buf_next;
  logic             below;
  logic             down_hit;

  assign buf_next = we_i ? wdata_i : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cmp_q <= '0;
    end else begin
      buf_q <= buf_next;
      if (!run_i || load_i) cmp_q <= buf_next;
    end
  end

  // level form of set-on-down-match / clear-on-up-match
  assign below    = cnt_i < cmp_q;
  assign down_hit = (cnt_i == cmp_q) && dir_i && (cmp_q != '0);
  assign pwm_o    = run_i && (center_i ? (below || down_hit) : below);

  // R6
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q == '0) |-> !pwm_o);

  // R7
  full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cmp_q > period_i && cnt_i <= period_i) |-> pwm_o);

  // R5
  down_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && center_i && dir_i && cnt_i == cmp_q && cmp_q != '0) |-> pwm_o);

  // R5
  up_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && center_i && !dir_i && cnt_i == cmp_q) |-> !pwm_o);

  // R3
  edge_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !center_i && cnt_i >= cmp_q) |-> !pwm_o);

  // R9
  hold_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> $stable(cmp_q));

  // R11
  direct_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && we_i) |=> (cmp_q == $past(wdata_i)));
endmodule

// File: rtl/pwm_center_gen.sv
module pwm_center_gen
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [N_CH-1:0]  duty_we_i,
  input  logic [CNT_W-1:0] duty_wdata_i,
  output logic [N_CH-1:0]  pwm_o,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o
);
  tb_mode_e         mode;
  logic [CNT_W-1:0] cnt;
  logic             dir;
  logic             run;
  logic             load;

  assign mode = tb_mode_e'(mode_i);

  pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .mode_i   (mode),
    .period_i (period_i),
    .cnt_o    (cnt),
    .dir_o    (dir),
    .run_o    (run),
    .load_o   (load)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .center_i (mode_i[1]),
      .run_i    (run),
      .load_i   (load),
      .cnt_i    (cnt),
      .dir_i    (dir),
      .period_i (period_i),
      .we_i     (duty_we_i[g]),
      .wdata_i  (duty_wdata_i),
      .pwm_o    (pwm_o[g])
    );
  end

  assign count_o = cnt;
  assign dir_o   = dir;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !dir_o && pwm_o == '0));
endmodule

// File: tb/pwm_center_gen_bench.sv
module pwm_center_gen_bench;
  localparam int CW = 16;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [CW-1:0] period = '0;
  logic [NC-1:0] we = '0;
  logic [CW-1:0] wdata = '0;
  logic [NC-1:0] pwm;
  logic [CW-1:0] cnt;
  logic          dir;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwm_center_gen #(.CNT_W(CW), .N_CH(NC)) u_pwm_center_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .period_i(period),
    .duty_we_i(we), .duty_wdata_i(wdata), .pwm_o(pwm), .count_o(cnt), .dir_o(dir)
  );

  typedef struct packed {
    logic [1:0]          md;
    logic [15:0]         per;
    logic [3:0][15:0]    duty;
    logic [3:0][15:0]    hi;
  } vec_t;

  // duty and hi listed as {ch3, ch2, ch1, ch0}
  localparam vec_t VECS [4] = '{
    '{2'b00, 16'd9, {16'd12, 16'd9, 16'd3, 16'd0}, {16'd10, 16'd9, 16'd3, 16'd0}},
    '{2'b10, 16'd8, {16'd9, 16'd7, 16'd3, 16'd0},  {16'd16, 16'd14, 16'd6, 16'd0}},
    '{2'b11, 16'd5, {16'd0, 16'd6, 16'd2, 16'd1},  {16'd0, 16'd10, 16'd4, 16'd2}},
    '{2'b00, 16'd4, {16'd0, 16'd2, 16'd5, 16'd1},  {16'd0, 16'd2, 16'd5, 16'd1}}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_duty(input int ch, input int val);
    we[ch] = 1'b1;
    wdata  = CW'(val);
    @(negedge clk);
    we = '0;
  endtask

  task automatic wait_at(input int c, input int d);
    for (int i = 0; i < 200; i++) begin
      if (int'(cnt) == c && int'(dir) == d) return;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [1:0] m, input int p, input int ch, input int d0);
    en = 1'b0;
    @(negedge clk);
    mode   = m;
    period = CW'(p);
    write_duty(ch, d0);
    en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #23;
    chk("R1 count", int'(cnt), 0);
    chk("R1 dir", int'(dir), 0);
    chk("R1 pwm", int'(pwm), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: high clocks per full cycle (R3 R5 R6 R7)
    foreach (VECS[v]) begin
      int win;
      int hi [NC];
      en = 1'b0;
      @(negedge clk);
      mode   = VECS[v].md;
      period = VECS[v].per;
      for (int c = 0; c < NC; c++) write_duty(c, int'(VECS[v].duty[c]));
      en = 1'b1;
      repeat (40) @(negedge clk);
      win = VECS[v].md[1] ? 2 * int'(VECS[v].per) : int'(VECS[v].per) + 1;
      for (int c = 0; c < NC; c++) hi[c] = 0;
      for (int k = 0; k < win; k++) begin
        for (int c = 0; c < NC; c++) hi[c] += int'(pwm[c]);
        @(negedge clk);
      end
      for (int c = 0; c < NC; c++)
        chk($sformatf("R3/R5/R6/R7 vec%0d ch%0d high", v, c), hi[c], int'(VECS[v].hi[c]));
    end

    // R11 disabled state
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle count", int'(cnt), 0);
    chk("R11 idle dir", int'(dir), 0);
    chk("R11 idle pwm", int'(pwm), 0);

    // R2 count/direction trace, P=4
    mode = 2'b10;
    period = CW'(4);
    en = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      int ec, ed;
      @(negedge clk);
      if (k <= 4) begin ec = k; ed = 0; end
      else if (k <= 8) begin ec = 8 - k; ed = 1; end
      else begin ec = k - 8; ed = 0; end
      chk($sformatf("R2 step%0d count", k), int'(cnt), ec);
      chk($sformatf("R2 step%0d dir", k), int'(dir), ed);
    end

    // R9 mode 10: new duty waits for bottom turnaround
    setup(2'b10, 8, 0, 2);
    wait_at(3, 0);
    write_duty(0, 6);
    wait_at(4, 1);
    chk("R9 before bottom load", int'(pwm[0]), 0);
    @(negedge clk);
    wait_at(4, 1);
    chk("R9 after bottom load", int'(pwm[0]), 1);

    // R10 mode 11: new duty applies from the top
    setup(2'b11, 8, 0, 2);
    wait_at(3, 0);
    write_duty(0, 6);
    chk("R10 not yet loaded", int'(pwm[0]), 0);
    wait_at(4, 1);
    chk("R10 after top load", int'(pwm[0]), 1);
    // and again at the bottom: lower duty takes effect on the up stroke
    wait_at(1, 1);
    write_duty(0, 1);
    wait_at(3, 0);
    chk("R10 after bottom load", int'(pwm[0]), 0);

    // R8 mode 00: new duty applies from the next period
    setup(2'b00, 9, 0, 2);
    wait_at(3, 0);
    write_duty(0, 6);
    wait_at(4, 0);
    chk("R8 same period", int'(pwm[0]), 0);
    @(negedge clk);
    wait_at(4, 0);
    chk("R8 next period", int'(pwm[0]), 1);

    // R11 write while disabled is used from the first clock after enable
    setup(2'b00, 9, 2, 5);
    chk("R11 direct duty first period", int'(pwm[2]), 1);
    wait_at(5, 0);
    chk("R11 direct duty edge", int'(pwm[2]), 0);

    // R4 single period then hold, then re-arm
    setup(2'b01, 3, 1, 2);
    chk("R4 first clock active", int'(pwm[1]), 1);
    repeat (10) @(negedge clk);
    chk("R4 held count", int'(cnt), 0);
    chk("R4 held pwm", int'(pwm[1]), 0);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R4 rearm count", int'(cnt), 1);
    chk("R4 rearm pwm", int'(pwm[1]), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule